// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the host controller's interrupt status word. Single-cycle event strobes from the transfer engine, the root ports, the asynchronous schedule and the microframe timer each set a sticky bit. Software reads the word through a small register port and clears bits by writing ones to them. A second register holds a per-bit enable mask. The block raises a single interrupt request whenever an enabled status bit is set.

Frame-list rollover is found inside the block by watching one bit of the running frame index. The size code of the frame list picks that bit. A registered copy of the watched bit is reloaded whenever the size code changes, so reprogramming the list size cannot raise a false rollover. The asynchronous-advance bit is armed by a doorbell strobe and fires once, on the next schedule advance.

All pins are plain control and status signals. There is no streaming interface, so there is no valid/ready handshake and no back-pressure. The register port is a single-cycle write strobe with a combinational read mux.

Top module: `usb_host_irq_status`

## Requirements
- R1: After reset the status word, the enable mask and `irq` are all zero.
- R2: A write to address 0 clears each status bit whose write-data bit is one. Status bits whose write-data bit is zero are unchanged.
- R3: Only status bits 0, 1, 2, 3, 5 and 7 exist (mask 0x0AF). All other bits of both registers always read as zero.
- R4: Bit 0 sets when `xfer_done` and `xfer_ioc` are high together. It also sets when `short_pkt` is high.
- R5: Bit 1 sets when `xfer_done` and `xfer_err` are high together. If `xfer_ioc` is also high, bit 0 sets in the same cycle.
- R6: Bit 2 sets when any of `port_conn_chg`, `port_en_chg` or `port_resume_jk` is high.
- R7: Bit 3 sets when `frame_index[13 - fl_size_code]` differs from its value in the previous cycle. Code 0 selects a 1024-entry list and code 7 selects an 8-entry list.
- R8: No rollover is reported in the first cycle after reset. No rollover is reported in any cycle where `fl_size_code` differs from its previous value.
- R9: Bit 5 sets on the first `async_adv` after an `adv_doorbell` strobe. Only one such event occurs per doorbell. An `adv_doorbell` in the same cycle as `async_adv` arms for a later advance.
- R10: Bit 7 sets on every `uframe_tick`.
- R11: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R12: Address 1 is the enable mask, which is readable and writable. `irq` is high exactly when (status AND enable) is nonzero.

Set events and writes take effect at the clock edge where they are sampled. Their results appear on `reg_rdata` and `irq` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_done | input | 1 | Transaction completed (strobe) |
| xfer_ioc | input | 1 | Descriptor of the completed transaction requests an interrupt |
| xfer_err | input | 1 | Completed transaction ended in error |
| short_pkt | input | 1 | Fewer bytes received than expected (strobe) |
| port_conn_chg | input | 1 | Connect status change on a port |
| port_en_chg | input | 1 | Port enable/disable change |
| port_resume_jk | input | 1 | Resume forced by J-K transition on a suspended port |
| adv_doorbell | input | 1 | Software rang the async-advance doorbell |
| async_adv | input | 1 | Asynchronous schedule advanced |
| uframe_tick | input | 1 | 125 µs microframe tick |
| frame_index | input | 14 | Running frame index |
| fl_size_code | input | 3 | Frame-list size code (0 = 1024 entries ... 7 = 8 entries) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = enable mask |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a hardware set and a software write-one clear of the same bit. The second is a doorbell ring and a schedule advance. Directed steps force both collisions on purpose: a tick together with a clearing write, and a ring together with an advance. A long random run produces them again along with size-code changes on top of rollovers. A behavioural model in the bench judges every cycle. It expects the set to win, and it expects a ring that coincides with an advance to fire only on a later advance.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int STAT_W   = 12;
  localparam int IDX_W    = 14;
  localparam int SIZE_W   = 3;
  localparam int TOP_BIT  = 13;

  localparam int B_XFER   = 0;
  localparam int B_ERR    = 1;
  localparam int B_PORT   = 2;
  localparam int B_ROLL   = 3;
  localparam int B_ADV    = 5;
  localparam int B_TICK   = 7;

  localparam logic [STAT_W-1:0] IMPL_MASK =
    STAT_W'((1 << B_XFER) | (1 << B_ERR) | (1 << B_PORT) |
            (1 << B_ROLL) | (1 << B_ADV) | (1 << B_TICK));

  typedef enum logic {ADDR_STATUS = 1'b0, ADDR_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/usbh_sts_bit.sv
module usbh_sts_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/usbh_roll_det.sv
module usbh_roll_det #(
  parameter int IDX_W   = 14,
  parameter int SIZE_W  = 3,
  parameter int TOP_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  frame_index,
  input  logic [SIZE_W-1:0] size_code,
  output logic              roll_o
);
  localparam int SEL_W = $clog2(IDX_W);

  logic [SEL_W-1:0]  bit_pos;
  logic              watched;
  logic              prev_q;
  logic              valid_q;
  logic [SIZE_W-1:0] size_q;

  always_comb begin
    bit_pos = SEL_W'(TOP_BIT) - SEL_W'(size_code);
    watched = frame_index[bit_pos];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
      size_q  <= '0;
    end else begin
      prev_q  <= watched;
      valid_q <= 1'b1;
      size_q  <= size_code;
    end
  end

  assign roll_o = valid_q && (size_q == size_code) && (watched != prev_q);

  assert_roll_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/usbh_adv_arm.sv
module usbh_adv_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_i,
  input  logic adv_i,
  output logic fire_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= ring_i | (armed_q & ~adv_i);
  end

  assign fire_o = armed_q & adv_i;

  assert_one_per_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !ring_i) |=> !fire_o);
endmodule

// File: rtl/usb_host_irq_status.sv
module usb_host_irq_status
  import usbh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_done,
  input  logic              xfer_ioc,
  input  logic              xfer_err,
  input  logic              short_pkt,
  input  logic              port_conn_chg,
  input  logic              port_en_chg,
  input  logic              port_resume_jk,
  input  logic              adv_doorbell,
  input  logic              async_adv,
  input  logic              uframe_tick,
  input  logic [IDX_W-1:0]  frame_index,
  input  logic [SIZE_W-1:0] fl_size_code,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              irq
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] enable_q;
  logic              roll_evt;
  logic              adv_evt;

  usbh_roll_det #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .TOP_BIT(TOP_BIT)) u_roll (
    .clk(clk), .rst_n(rst_n), .frame_index(frame_index),
    .size_code(fl_size_code), .roll_o(roll_evt)
  );

  usbh_adv_arm u_adv (
    .clk(clk), .rst_n(rst_n), .ring_i(adv_doorbell),
    .adv_i(async_adv), .fire_o(adv_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_XFER] = (xfer_done & xfer_ioc) | short_pkt;
    set_vec[B_ERR]  = xfer_done & xfer_err;
    set_vec[B_PORT] = port_conn_chg | port_en_chg | port_resume_jk;
    set_vec[B_ROLL] = roll_evt;
    set_vec[B_ADV]  = adv_evt;
    set_vec[B_TICK] = uframe_tick;
    clr_vec = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata : '0;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      usbh_sts_bit u_bit (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec[i]),
        .clr_i(clr_vec[i]), .q_o(status[i])
      );
    end else begin : g_rsvd
      assign status[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            enable_q <= '0;
    else if (reg_wr && reg_addr == ADDR_ENABLE) enable_q <= reg_wdata & IMPL_MASK;
  end

  assign reg_rdata = (reg_addr == ADDR_ENABLE) ? enable_q : status;
  assign irq       = |(status & enable_q);

  assert_err_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_err && xfer_ioc) |=> (status[B_XFER] && status[B_ERR]));
  assert_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick |=> status[B_TICK]);
  assert_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_conn_chg || port_en_chg || port_resume_jk) |=> status[B_PORT]);
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_ENABLE && reg_wdata == '0) |=> !irq);
endmodule

// File: tb/usb_host_irq_status_bench.sv
module usb_host_irq_status_bench;
  localparam int MASK = 'h0AF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_done = 0, xfer_ioc = 0, xfer_err = 0, short_pkt = 0;
  logic port_conn_chg = 0, port_en_chg = 0, port_resume_jk = 0;
  logic adv_doorbell = 0, async_adv = 0, uframe_tick = 0;
  logic [13:0] frame_index = '0;
  logic [2:0]  fl_size_code = '0;
  logic        reg_wr = 0, reg_addr = 0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        irq;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usb_host_irq_status u_usb_host_irq_status (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_ioc(xfer_ioc),
    .xfer_err(xfer_err), .short_pkt(short_pkt), .port_conn_chg(port_conn_chg),
    .port_en_chg(port_en_chg), .port_resume_jk(port_resume_jk),
    .adv_doorbell(adv_doorbell), .async_adv(async_adv), .uframe_tick(uframe_tick),
    .frame_index(frame_index), .fl_size_code(fl_size_code), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference
  int m_stat = 0, m_en = 0, m_size = 0;
  bit m_armed = 0, m_prev = 0, m_valid = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_size = 0; m_armed = 0; m_prev = 0; m_valid = 0;
    end else begin
      int ev;
      bit b;
      ev = 0;
      if ((xfer_done && xfer_ioc) || short_pkt) ev |= 1;
      if (xfer_done && xfer_err) ev |= 2;
      if (port_conn_chg || port_en_chg || port_resume_jk) ev |= 4;
      b = frame_index[13 - int'(fl_size_code)];
      if (m_valid && m_size == int'(fl_size_code) && b != m_prev) ev |= 8;
      if (async_adv && m_armed) ev |= 'h20;
      if (uframe_tick) ev |= 'h80;
      m_prev = b; m_size = int'(fl_size_code); m_valid = 1;
      m_armed = adv_doorbell || (m_armed && !async_adv);
      if (reg_wr && !reg_addr) m_stat = ev | (m_stat & ~int'(reg_wdata));
      else m_stat = ev | m_stat;
      if (reg_wr && reg_addr) m_en = int'(reg_wdata) & MASK;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    check(int'(reg_rdata) == (reg_addr ? m_en : m_stat), "R3 model rdata",
          int'(reg_rdata), reg_addr ? m_en : m_stat);
    check(irq == ((m_stat & m_en) != 0), "R12 model irq", int'(irq),
          int'((m_stat & m_en) != 0));
  endtask

  task automatic clear_strobes();
    xfer_done = 0; xfer_ioc = 0; xfer_err = 0; short_pkt = 0;
    port_conn_chg = 0; port_en_chg = 0; port_resume_jk = 0;
    adv_doorbell = 0; async_adv = 0; uframe_tick = 0; reg_wr = 0;
  endtask

  task automatic expect_stat(int exp, string tag);
    reg_addr = 0; #1;
    check(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(bit a, int d);
    reg_wr = 1; reg_addr = a; reg_wdata = 12'(d);
    cyc(); clear_strobes(); reg_addr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_stat(0, "R1 status reset");
    reg_addr = 1; #1; check(reg_rdata == 0, "R1 enable reset", int'(reg_rdata), 0);
    check(irq == 0, "R1 irq reset", int'(irq), 0);
    reg_addr = 0;
    @(posedge clk); #2; rst_n = 1;
    cyc(); expect_stat(0, "R8 no roll after reset");

    xfer_done = 1; xfer_ioc = 1; cyc(); clear_strobes();
    expect_stat('h001, "R4 ioc complete");
    wr(0, 'h001); expect_stat(0, "R2 w1c clears");
    short_pkt = 1; cyc(); clear_strobes(); expect_stat('h001, "R4 short packet");
    wr(0, 'h000); expect_stat('h001, "R2 zero write no effect");
    wr(0, 'hFFF); expect_stat(0, "R2 clear all");
    xfer_done = 1; xfer_err = 1; xfer_ioc = 1; cyc(); clear_strobes();
    expect_stat('h003, "R5 error with ioc");
    wr(0, 'hFFF);
    xfer_done = 1; xfer_err = 1; cyc(); clear_strobes();
    expect_stat('h002, "R5 error alone");
    wr(0, 'hFFF);
    port_resume_jk = 1; cyc(); clear_strobes(); expect_stat('h004, "R6 jk resume");
    wr(0, 'h004);
    port_en_chg = 1; cyc(); clear_strobes(); expect_stat('h004, "R6 enable change");
    wr(0, 'h004);
    uframe_tick = 1; cyc(); clear_strobes(); expect_stat('h080, "R10 tick");
    wr(0, 'h080);
    async_adv = 1; cyc(); clear_strobes(); expect_stat(0, "R9 advance without ring");
    adv_doorbell = 1; async_adv = 1; cyc(); clear_strobes();
    expect_stat(0, "R9 ring with advance");
    async_adv = 1; cyc(); clear_strobes(); expect_stat('h020, "R9 advance after ring");
    wr(0, 'h020);
    async_adv = 1; cyc(); clear_strobes(); expect_stat(0, "R9 once per ring");

    fl_size_code = 7; cyc(); expect_stat(0, "R8 size change reload");
    frame_index = 14'd64; cyc(); expect_stat('h008, "R7 bit6 toggle");
    wr(0, 'h008);
    frame_index = 14'h80; fl_size_code = 6; cyc();
    expect_stat(0, "R8 no false roll on resize");
    cyc(); expect_stat(0, "R8 steady");
    frame_index = 14'h00; cyc(); expect_stat('h008, "R7 bit7 toggle");
    wr(0, 'h008);
    fl_size_code = 0; cyc();
    frame_index = 14'h2000; cyc(); expect_stat('h008, "R7 bit13 toggle");
    wr(0, 'h008);

    uframe_tick = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 12'h080; cyc();
    clear_strobes(); expect_stat('h080, "R11 set beats clear");
    wr(1, 'hFFF); reg_addr = 1; #1;
    check(reg_rdata == 12'h0AF, "R3 enable reserved zero", int'(reg_rdata), 'h0AF);
    check(irq == 1, "R12 irq on enabled bit", int'(irq), 1);
    reg_addr = 0;
    wr(1, 'h000); check(irq == 0, "R12 irq masked", int'(irq), 0);
    wr(0, 'hFFF);

    for (int n = 0; n < 4000; n++) begin
      xfer_done = ($urandom % 6) == 0; xfer_ioc = $urandom % 2;
      xfer_err = ($urandom % 3) == 0; short_pkt = ($urandom % 10) == 0;
      port_conn_chg = ($urandom % 20) == 0; port_en_chg = ($urandom % 20) == 0;
      port_resume_jk = ($urandom % 20) == 0;
      adv_doorbell = ($urandom % 12) == 0; async_adv = ($urandom % 5) == 0;
      uframe_tick = ($urandom % 8) == 0;
      frame_index = frame_index + 14'(1 + ($urandom % 3));
      if (($urandom % 150) == 0) fl_size_code = 3'($urandom);
      reg_wr = ($urandom % 4) == 0; reg_addr = ($urandom % 5) == 0;
      reg_wdata = 12'($urandom);
      cyc();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule